// File: doc/BRIEF.md
# Serial Real-Time Clock and Parameter Memory Device

This block is the slave end of a chip-select-framed serial link. It keeps a free-running 32-bit count of seconds and a 64-byte parameter memory. A host raises the select line, clocks in a command word most significant bit first, and then clocks 32-bit data words in or out. It drops the select line when the access is complete. The command can ask for a fixed identification word, read or set the seconds counter, or read or write a burst of the parameter memory starting at any byte.

All three serial inputs are resynchronised to the system clock. The device samples the data input on each detected rising edge of the serial clock. Each outgoing bit is placed on the output shortly after a rising edge, and the host samples it at the next rising edge.

The counter holds raw seconds only. Any calendar offset that software keeps in the memory, in bytes 8 to 11, is added by the host and never by the device.

Top module: `rtcs_serial_dev`

## Requirements
- R1: With select asserted, a first 16 bits of all zero end the command. The next 32 bits clocked out are the identification word 0xFFFFF308, most significant bit first.
- R2: The 32-bit command 0x20000000 returns the seconds counter in the following 32 bits, sampled when the command completes. After reset the counter is 0.
- R3: The command 0xA0000000 (bit 31 set) followed by 32 data bits loads the counter on the last data bit. The tick prescaler restarts from zero at that moment.
- R4: The counter advances by one every TICK_DIV clock cycles and wraps from 0xFFFFFFFF to 0.
- R5: The command 0xA0000100 + n (n in 0..63) writes each complete 8-bit group that follows to memory byte n, n+1, and so on. The address wraps from 63 to 0.
- R6: The command 0x20000100 + n streams memory bytes n, n+1, ... without a break for as long as select stays high. Each byte goes out most significant bit first, and the address wraps from 63 to 0.
- R7: Dropping select at any bit position returns the decoder to the start of a command. A partly shifted byte or counter word is discarded.
- R8: Any other command (including a memory offset of 64 or more) drives 0 and changes nothing until select falls. After the 32 bits of an identification or counter read the output is also 0.
- R9: The data output is 0 while select is low.
- R10: Writing memory bytes 8 to 11 does not change the counter value returned by a read.
- R11: An output bit is valid from a few clock cycles after the rising serial edge that precedes it. The first data bit is valid after the rising edge of the last command bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Device select, active high; serial clock must be low when it rises |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data into the device, sampled on rising serial edges |
| sdo_o | output | 1 | Serial data out of the device, registered |

## Verification
Each serial edge reaches the decoder three clock cycles after it occurs (two synchroniser stages and the edge detector), and the output register adds one more cycle. The first memory byte of a read burst needs two further cycles for the memory read. The bench holds each serial clock level for six system cycles and samples the output just before the next rising edge, which is at least twelve cycles after the edge that produced the bit, so every sample lands after the value has settled. The counter checks place the counter snapshot (taken at command completion) in windows well clear of a prescaler tick, so the expected seconds value is fixed by the requirements alone.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
  localparam logic [31:0] ID_WORD   = 32'hFFFFF308;
  localparam logic [30:0] CLK_REGN  = 31'h20000000;
  localparam logic [30:0] MEM_REGN  = 31'h20000100;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ID_OUT,
    ST_CLK_RD,
    ST_CLK_WR,
    ST_MEM_RD,
    ST_MEM_WR,
    ST_MUTE
  } dev_state_e;
endpackage

// File: rtl/rtcs_sync.sv
module rtcs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rtcs_seconds.sv
module rtcs_seconds #(
  parameter int TICK_DIV = 32768,
  parameter int PW       = $clog2(TICK_DIV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [31:0]   load_val,
  output logic [31:0]   sec_q,
  output logic [PW-1:0] pre_q
);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [PW-1:0] PRE_ONE  = PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      sec_q <= '0;
    end else if (load) begin
      pre_q <= '0;
      sec_q <= load_val;
    end else if (pre_q == PRE_LAST) begin
      pre_q <= '0;
      sec_q <= sec_q + 32'd1;
    end else begin
      pre_q <= pre_q + PRE_ONE;
    end
  end
endmodule

// File: rtl/rtcs_param_mem.sv
module rtcs_param_mem #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/rtcs_serial_dev.sv
module rtcs_serial_dev
  import rtcs_pkg::*;
#(
  parameter int TICK_DIV  = 32768,
  parameter int MEM_BYTES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o
);
  localparam int AW    = $clog2(MEM_BYTES);
  localparam int PRE_W = $clog2(TICK_DIV);
  localparam logic [AW-1:0] A_ONE = AW'(1);

  logic [2:0]    sync_q;
  logic          sel_s, sclk_s, sdi_s, sclk_d, rise;
  dev_state_e    state;
  logic [5:0]    cnt;
  logic [31:0]   shin, shout, in_next;
  logic [AW-1:0] addr_rd, addr_wr, waddr;
  logic [1:0]    pend;
  logic          mem_we, sec_load, sdo_q;
  logic [7:0]    wdata, mem_q;
  logic [31:0]   load_val, sec_q;
  logic [PRE_W-1:0] pre_q;

  rtcs_sync #(.W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sel_i, sclk_i, sdi_i}),
    .q   (sync_q)
  );

  assign sel_s   = sync_q[2];
  assign sclk_s  = sync_q[1];
  assign sdi_s   = sync_q[0];
  assign rise    = sel_s & sclk_s & ~sclk_d;
  assign in_next = {shin[30:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  rtcs_seconds #(.TICK_DIV(TICK_DIV), .PW(PRE_W)) u_sec (
    .clk      (clk),
    .rst      (rst),
    .load     (sec_load),
    .load_val (load_val),
    .sec_q    (sec_q),
    .pre_q    (pre_q)
  );

  rtcs_param_mem #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (addr_rd),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_CMD;
      cnt      <= '0;
      shin     <= '0;
      shout    <= '0;
      addr_rd  <= '0;
      addr_wr  <= '0;
      waddr    <= '0;
      wdata    <= '0;
      pend     <= '0;
      mem_we   <= 1'b0;
      sec_load <= 1'b0;
      load_val <= '0;
      sdo_q    <= 1'b0;
    end else begin
      mem_we   <= 1'b0;
      sec_load <= 1'b0;
      pend     <= {pend[0], 1'b0};
      if (pend[1]) begin
        shout[31:24] <= mem_q;
        addr_rd      <= addr_rd + A_ONE;
      end
      if (!sel_s) begin
        state <= ST_CMD;
        cnt   <= '0;
        shin  <= '0;
      end else if (rise) begin
        unique case (state)
          ST_CMD: begin
            shin <= in_next;
            cnt  <= cnt + 6'd1;
            if (cnt == 6'd15 && in_next[15:0] == 16'h0000) begin
              state <= ST_ID_OUT;
              shout <= ID_WORD;
              cnt   <= '0;
            end else if (cnt == 6'd31) begin
              cnt <= '0;
              if (in_next[30:0] == CLK_REGN) begin
                state <= in_next[31] ? ST_CLK_WR : ST_CLK_RD;
                shout <= sec_q;
              end else if (in_next[30:AW] == MEM_REGN[30:AW]) begin
                addr_rd <= in_next[AW-1:0];
                addr_wr <= in_next[AW-1:0];
                if (in_next[31]) begin
                  state <= ST_MEM_WR;
                end else begin
                  state <= ST_MEM_RD;
                  pend  <= 2'b01;
                end
              end else begin
                state <= ST_MUTE;
              end
            end
          end
          ST_ID_OUT, ST_CLK_RD: begin
            shout <= {shout[30:0], 1'b0};
            cnt   <= cnt + 6'd1;
            if (cnt == 6'd31) state <= ST_MUTE;
          end
          ST_CLK_WR: begin
            shin <= in_next;
            cnt  <= cnt + 6'd1;
            if (cnt == 6'd31) begin
              sec_load <= 1'b1;
              load_val <= in_next;
              state    <= ST_MUTE;
            end
          end
          ST_MEM_RD: begin
            shout <= {shout[30:0], 1'b0};
            cnt   <= cnt + 6'd1;
            if (cnt[2:0] == 3'd7) begin
              shout[31:24] <= mem_q;
              addr_rd      <= addr_rd + A_ONE;
            end
          end
          ST_MEM_WR: begin
            shin <= in_next;
            cnt  <= cnt + 6'd1;
            if (cnt[2:0] == 3'd7) begin
              mem_we  <= 1'b1;
              wdata   <= in_next[7:0];
              waddr   <= addr_wr;
              addr_wr <= addr_wr + A_ONE;
            end
          end
          default: ;
        endcase
      end
      sdo_q <= sel_s && shout[31] &&
               (state == ST_ID_OUT || state == ST_CLK_RD || state == ST_MEM_RD);
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/rtcs_checker.sv
module rtcs_checker #(
  parameter int PW = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          sel_i,
  input logic          sdo_o,
  input logic          sel_s,
  input logic          mem_we,
  input logic          sec_load,
  input logic [31:0]   load_val,
  input logic [31:0]   sec_q,
  input logic [PW-1:0] pre_q
);
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!sel_i && $past(!sel_i) && $past(!sel_i, 2) && $past(!sel_i, 3)) |-> !sdo_o); // R9

  AST_WRITE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(sel_s)); // R7

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    $past(sec_load) |-> (sec_q == $past(load_val))); // R3

  AST_PRESCALE_RESTART: assert property (@(posedge clk) disable iff (rst)
    $past(sec_load) |-> (pre_q == '0)); // R3

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(sec_load) |-> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 32'd1)); // R4
endmodule

bind rtcs_serial_dev rtcs_checker #(.PW(PRE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_i    (sel_i),
  .sdo_o    (sdo_o),
  .sel_s    (sel_s),
  .mem_we   (mem_we),
  .sec_load (sec_load),
  .load_val (load_val),
  .sec_q    (sec_q),
  .pre_q    (pre_q)
);

// File: tb/sim_rtcs_serial_dev.sv
`timescale 1ns/1ps
module sim_rtcs_serial_dev;
  localparam int TICKS = 4000;
  localparam int HALF  = 6;

  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 read, 2 id, 3 muted read
    logic [31:0] cmd;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd2, 32'h00000000, 32'hFFFFF308},
    '{2'd0, 32'hA0000100, 32'h11223344},
    '{2'd0, 32'hA0000104, 32'h55667788},
    '{2'd1, 32'h20000100, 32'h11223344},
    '{2'd1, 32'h20000104, 32'h55667788},
    '{2'd1, 32'h20000102, 32'h33445566},
    '{2'd0, 32'hA000013E, 32'hAABBCCDD},
    '{2'd1, 32'h2000013E, 32'hAABBCCDD},
    '{2'd1, 32'h20000100, 32'hCCDD3344},
    '{2'd3, 32'h30000000, 32'h00000000},
    '{2'd0, 32'hA0000140, 32'h12345678},
    '{2'd1, 32'h20000101, 32'hDD334455}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtcs_serial_dev #(.TICK_DIV(TICKS), .MEM_BYTES(64)) u0 (
    .clk(clk), .rst(rst), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic o);
    sdi = b;
    wait_cyc(HALF);
    o = sdo;
    sclk = 1'b1;
    wait_cyc(HALF);
    sclk = 1'b0;
  endtask

  task automatic shift(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic o;
    dout = '0;
    for (int i = n - 1; i >= 0; i--) begin
      xbit(din[i], o);
      dout = {dout[62:0], o};
    end
  endtask

  task automatic sel_on();
    sel = 1'b1;
    wait_cyc(4);
  endtask

  task automatic sel_off();
    sel = 1'b0;
    sdi = 1'b0;
    wait_cyc(8);
  endtask

  task automatic word_read(input logic [31:0] cmd, output logic [31:0] r);
    logic [63:0] d;
    sel_on();
    shift(32, {32'h0, cmd}, d);
    shift(32, 64'h0, d);
    r = d[31:0];
    sel_off();
  endtask

  task automatic word_write(input logic [31:0] cmd, input logic [31:0] v);
    logic [63:0] d;
    sel_on();
    shift(32, {32'h0, cmd}, d);
    shift(32, {32'h0, v}, d);
    sel_off();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] d;
    wait_cyc(6);
    rst = 1'b0;
    wait_cyc(3);
    check("R9 reset output low", {63'h0, sdo}, 64'h0);
    word_read(32'h20000000, r);
    check("R2 counter zero after reset", {32'h0, r}, 64'h0);

    // table walk
    foreach (VECS[i]) begin
      case (VECS[i].kind)
        2'd0: word_write(VECS[i].cmd, VECS[i].data);
        2'd1: begin
          word_read(VECS[i].cmd, r);
          check("R6 R5 R11 table word read", {32'h0, r}, {32'h0, VECS[i].data});
        end
        2'd2: begin
          sel_on();
          shift(16, 64'h0, d);
          shift(32, 64'h0, d);
          sel_off();
          check("R1 R11 identification", d, {32'h0, VECS[i].data});
        end
        default: begin
          word_read(VECS[i].cmd, r);
          check("R8 unknown command muted", {32'h0, r}, 64'h0);
        end
      endcase
    end

    // R8: bits after identification are zero
    sel_on();
    shift(16, 64'h0, d);
    shift(40, 64'h0, d);
    sel_off();
    check("R8 zeros after id word", d, 64'h000000FFFFF30800);

    // R3: prescaler restart on load
    word_write(32'hA0000000, 32'h00000100);
    wait_cyc(2500);
    word_write(32'hA0000000, 32'h00000200);
    wait_cyc(3300);
    word_read(32'h20000000, r);
    check("R3 load value, prescaler restarted", {32'h0, r}, 64'h200);
    wait_cyc(1000);
    word_read(32'h20000000, r);
    check("R4 one tick", {32'h0, r}, 64'h201);
    wait_cyc(3000);
    word_read(32'h20000000, r);
    check("R4 second tick", {32'h0, r}, 64'h202);

    // R4 wrap
    word_write(32'hA0000000, 32'hFFFFFFFF);
    wait_cyc(3000);
    word_read(32'h20000000, r);
    check("R4 before wrap", {32'h0, r}, 64'hFFFFFFFF);
    wait_cyc(1200);
    word_read(32'h20000000, r);
    check("R4 wrap to zero", {32'h0, r}, 64'h0);

    // R10 offset bytes, R7 aborted counter write
    word_write(32'hA0000000, 32'h12345678);
    word_write(32'hA0000108, 32'h7FFFFFFF);
    sel_on();
    shift(32, 64'hA0000000, d);
    shift(20, 64'hFFFFF, d);
    sel_off();
    word_read(32'h20000000, r);
    check("R10 R7 counter unaffected", {32'h0, r}, 64'h12345678);
    word_read(32'h20000108, r);
    check("R5 offset bytes stored", {32'h0, r}, 64'h7FFFFFFF);

    // R7 partial byte discarded
    word_write(32'hA0000110, 32'h01020304);
    sel_on();
    shift(32, 64'hA0000110, d);
    shift(12, 64'h5A3, d);
    sel_off();
    word_read(32'h20000110, r);
    check("R7 partial byte discarded", {32'h0, r}, 64'h5A020304);

    // R7 mid-command abort
    sel_on();
    shift(10, 64'h3FF, d);
    sel_off();
    sel_on();
    shift(16, 64'h0, d);
    shift(32, 64'h0, d);
    sel_off();
    check("R7 decoder reset by deselect", d, 64'hFFFFF308);

    // R5 / R6 full bursts with wrap
    sel_on();
    shift(32, 64'hA0000100, d);
    for (int k = 0; k < 64; k++) shift(8, 64'((k * 5 + 3) & 255), d);
    sel_off();
    sel_on();
    shift(32, 64'h2000013C, d);
    for (int j = 0; j < 70; j++) begin
      shift(8, 64'h0, d);
      check("R6 R5 burst byte", d, 64'((((60 + j) % 64) * 5 + 3) & 255));
    end
    sel_off();
    check("R9 output low after deselect", {63'h0, sdo}, 64'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule